// File: doc/BRIEF.md
# Sampling Pipeline Write/Read Sequencer

This block sequences a circular bank of analog sampling cells that many channels share. While it is acquiring, every write slot strobe stores a sample into the next cell, and the write index wraps at the end of the bank. The block supplies the cell indices and the control strobes. The cells, the read amplifier and the converter are outside it and appear only as a digitize-start pulse and a completion input.

The mode and the pairing option are captured when a start is accepted. In separate mode, a stop request freezes writing. The block then walks a read index over every cell, beginning with the oldest cell and moving in write order, at the slower read slot rate. It starts one digitize at a time. In concurrent mode, writing goes on. Each write slot also reads the cell written a fixed number of slots earlier. A slot that finds the converter still busy raises a sticky overrun flag.

In the difference option the converter pairs cell n-1 with cell n. The first cell of a sequence therefore has no partner and is not digitized. In the cell-only option the converter pairs a fixed reference with cell n.

Top module: `pipe_seq`

## Requirements
- R1: After reset, wrCell and rdCell are 0, and wrStb, convStart, acquiring, busy, overrun and usePrev are all 0.
- R2: startReq is accepted only when the block is idle (acquiring=0, busy=0). It latches concMode and diffMode, and acquiring rises in the next cycle. A startReq while busy is ignored, so acquiring stays 0.
- R3: While acquiring and no stopReq is present, each wrTick gives wrStb in the same cycle with wrCell naming the cell written. wrCell then advances by one and wraps from CELLS-1 (63) to 0.
- R4: A stopReq while acquiring ends writing at that edge, and a wrTick in the stop cycle writes nothing. busy rises in the next cycle. wrStb is never high while busy is high.
- R5: In separate mode, reading starts at the cell wrCell named at the stop and covers all CELLS cells in ascending order with wrap. A cell is digitized on an rdTick only when no conversion is outstanding, with convStart high in that cycle and rdCell held until convDone.
- R6: In the cell-only option (diffMode=0) a separate read-out issues CELLS (64) convStart pulses, and usePrev is 0.
- R7: In the difference option (diffMode=1), usePrev is 1. The first cell of a read-out advances on its rdTick without a convStart, so a separate read-out issues CELLS-1 (63) pulses.
- R8: In separate mode, busy falls in the cycle after the convDone of the last cell, and the block is idle again.
- R9: In concurrent mode the first LAT (4) write slots read nothing. Each later write slot also reads cell (wrCell - LAT) mod CELLS, with convStart in the same cycle. In the difference option the first such slot issues no convStart.
- R10: A concurrent read slot that arrives while a conversion is outstanding (convDone not high in that cycle) issues no convStart. It sets overrun from the next cycle, and overrun stays set until the next accepted start.
- R11: After a concurrent-mode stop, busy stays high until the outstanding conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrTick | input | 1 | Write slot strobe, one cycle |
| rdTick | input | 1 | Read slot strobe for separate mode, one cycle |
| startReq | input | 1 | Begin acquisition |
| stopReq | input | 1 | End acquisition |
| concMode | input | 1 | 1 = concurrent, 0 = separate (latched at start) |
| diffMode | input | 1 | 1 = neighbour difference, 0 = cell against reference (latched at start) |
| convDone | input | 1 | Converter finished the current digitize |
| wrStb | output | 1 | Write the cell on wrCell in this cycle |
| wrCell | output | 6 | Write cell index |
| rdCell | output | 6 | Read cell index |
| convStart | output | 1 | Start digitizing rdCell, one cycle |
| usePrev | output | 1 | First converter value is cell n-1 rather than the reference |
| acquiring | output | 1 | Acquisition running |
| busy | output | 1 | From the stop until the last digitize completes |
| overrun | output | 1 | Sticky: a concurrent read slot was missed |

## Verification
wrStb and convStart are combinational on the slot strobes, so the bench checks them, together with wrCell and rdCell, in the same cycle as the wrTick or rdTick. busy and acquiring are registered and are checked one cycle after the stop, start or final convDone. overrun is checked one cycle after the missed slot. All inputs change shortly after the rising edge, and all outputs are sampled on the falling edge. A scoreboard queue holds the expected separate-mode read order and is consumed in step with each convStart. Concurrent-mode expectations come from the bench's own count of write slots and outstanding conversions.

// File: rtl/pipe_seq_pkg.sv
package pipe_seq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ACQ, SQ_READ, SQ_DRAIN} seqState_t;

  typedef struct packed {
    logic wrAdv;
    logic rdAdv;
    logic rdLoad;
  } seqStrobe_t;
endpackage

// File: rtl/pipe_seq_ctrl.sv
module pipe_seq_ctrl
  import pipe_seq_pkg::*;
#(
  parameter int CELLS = 64,
  parameter int LAT   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrTick,
  input  logic       rdTick,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       concMode,
  input  logic       diffMode,
  input  logic       convDone,
  output seqStrobe_t stb,
  output logic       wrStb,
  output logic       convStart,
  output logic       usePrev,
  output logic       acquiring,
  output logic       busy,
  output logic       overrun
);
  localparam int AW = $clog2(CELLS);
  localparam int LW = $clog2(LAT + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(CELLS - 1);
  localparam logic [LW-1:0] FILL_MAX = LW'(LAT);

  seqState_t state;
  logic convBusy, firstRd, modeLat, diffLat, ovrReg;
  logic [AW-1:0] rdIdx;
  logic [LW-1:0] fillCnt;

  logic busyNow, startOk, wrGo, fillDone, concSlot, skipDiff;
  logic concConv, concOvr, readSlot, sepSkip, sepConv, sepDone, sepAdv;
  logic stopSep, stopAny;

  always_comb begin
    busyNow  = convBusy & ~convDone;
    startOk  = (state == SQ_IDLE) & startReq;
    stopAny  = (state == SQ_ACQ) & stopReq;
    stopSep  = stopAny & ~modeLat;
    wrGo     = (state == SQ_ACQ) & wrTick & ~stopReq;
    fillDone = (fillCnt == FILL_MAX);
    concSlot = wrGo & modeLat & fillDone;
    skipDiff = diffLat & firstRd;
    concConv = concSlot & ~skipDiff & ~busyNow;
    concOvr  = concSlot & ~skipDiff & busyNow;
    readSlot = (state == SQ_READ) & rdTick & ~convBusy;
    sepSkip  = readSlot & diffLat & (rdIdx == '0);
    sepConv  = readSlot & ~(diffLat & (rdIdx == '0));
    sepDone  = (state == SQ_READ) & convBusy & convDone;
    sepAdv   = sepSkip | sepDone;
  end

  assign stb.wrAdv  = wrGo;
  assign stb.rdAdv  = concSlot | sepAdv;
  assign stb.rdLoad = startOk | stopSep;
  assign wrStb      = wrGo;
  assign convStart  = concConv | sepConv;
  assign usePrev    = diffLat;
  assign acquiring  = (state == SQ_ACQ);
  assign busy       = (state == SQ_READ) | (state == SQ_DRAIN);
  assign overrun    = ovrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SQ_IDLE;
      convBusy <= 1'b0;
      firstRd  <= 1'b0;
      modeLat  <= 1'b0;
      diffLat  <= 1'b0;
      ovrReg   <= 1'b0;
      rdIdx    <= '0;
      fillCnt  <= '0;
    end else begin
      case (state)
        SQ_IDLE:  if (startOk) state <= SQ_ACQ;
        SQ_ACQ:   if (stopReq) state <= modeLat ? SQ_DRAIN : SQ_READ;
        SQ_READ:  if (sepAdv && rdIdx == LAST_IDX) state <= SQ_IDLE;
        SQ_DRAIN: if (!busyNow) state <= SQ_IDLE;
        default:  state <= SQ_IDLE;
      endcase

      if (convStart)     convBusy <= 1'b1;
      else if (convDone) convBusy <= 1'b0;

      if (startOk) begin
        modeLat <= concMode;
        diffLat <= diffMode;
        firstRd <= 1'b1;
        fillCnt <= '0;
        ovrReg  <= 1'b0;
      end else begin
        if (concSlot)            firstRd <= 1'b0;
        if (wrGo && !fillDone)   fillCnt <= fillCnt + 1'b1;
        if (concOvr)             ovrReg  <= 1'b1;
      end

      if (stopSep)     rdIdx <= '0;
      else if (sepAdv) rdIdx <= rdIdx + 1'b1;
    end
  end

  assert_single_conv_R5: assert property (@(posedge clk) disable iff (!rstN)
    (convBusy && !convDone) |-> !convStart);
  assert_no_write_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !wrStb);
  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> !acquiring);
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !startReq) |=> overrun);
  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !convBusy);
endmodule

// File: rtl/pipe_seq_path.sv
module pipe_seq_path
  import pipe_seq_pkg::*;
#(
  parameter int CELLS = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               stb,
  output logic [$clog2(CELLS)-1:0] wrCell,
  output logic [$clog2(CELLS)-1:0] rdCell
);
  localparam int AW = $clog2(CELLS);
  localparam logic [AW-1:0] LAST_IDX = AW'(CELLS - 1);

  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextCell(input logic [AW-1:0] c);
    return (c == LAST_IDX) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.wrAdv)       wrPtr <= nextCell(wrPtr);
      if (stb.rdLoad)      rdPtr <= wrPtr;
      else if (stb.rdAdv)  rdPtr <= nextCell(rdPtr);
    end
  end

  assign wrCell = wrPtr;
  assign rdCell = rdPtr;

  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.rdAdv && !stb.rdLoad) |=> $stable(rdPtr));
  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrAdv |=> $stable(wrPtr));
endmodule

// File: rtl/pipe_seq.sv
module pipe_seq
  import pipe_seq_pkg::*;
#(
  parameter int CELLS = 64,
  parameter int LAT   = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrTick,
  input  logic                     rdTick,
  input  logic                     startReq,
  input  logic                     stopReq,
  input  logic                     concMode,
  input  logic                     diffMode,
  input  logic                     convDone,
  output logic                     wrStb,
  output logic [$clog2(CELLS)-1:0] wrCell,
  output logic [$clog2(CELLS)-1:0] rdCell,
  output logic                     convStart,
  output logic                     usePrev,
  output logic                     acquiring,
  output logic                     busy,
  output logic                     overrun
);
  seqStrobe_t stb;

  pipe_seq_ctrl #(.CELLS(CELLS), .LAT(LAT)) uCtrl (
    .clk(clk), .rstN(rstN), .wrTick(wrTick), .rdTick(rdTick),
    .startReq(startReq), .stopReq(stopReq), .concMode(concMode),
    .diffMode(diffMode), .convDone(convDone), .stb(stb), .wrStb(wrStb),
    .convStart(convStart), .usePrev(usePrev), .acquiring(acquiring),
    .busy(busy), .overrun(overrun)
  );

  pipe_seq_path #(.CELLS(CELLS)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrCell(wrCell), .rdCell(rdCell)
  );
endmodule

// File: tb/sim_pipe_seq.sv
module sim_pipe_seq;
  localparam int CELLS = 64;
  localparam int LAT   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrTick = 1'b0, rdTick = 1'b0, startReq = 1'b0, stopReq = 1'b0;
  logic concMode = 1'b0, diffMode = 1'b0, convDone = 1'b0;
  logic wrStb, convStart, usePrev, acquiring, busy, overrun;
  logic [5:0] wrCell, rdCell;

  always #10 clk = ~clk;

  pipe_seq #(.CELLS(CELLS), .LAT(LAT)) u0 (
    .clk(clk), .rstN(rstN), .wrTick(wrTick), .rdTick(rdTick),
    .startReq(startReq), .stopReq(stopReq), .concMode(concMode),
    .diffMode(diffMode), .convDone(convDone), .wrStb(wrStb), .wrCell(wrCell),
    .rdCell(rdCell), .convStart(convStart), .usePrev(usePrev),
    .acquiring(acquiring), .busy(busy), .overrun(overrun)
  );

  int nChk = 0, nBad = 0;
  int expQ[$];
  int wrPer = 5, rdPer = 7, convLat = 3;
  int wCnt = 0, rCnt = 0, convCnt = 0;
  int expW = 0, slotIdx = 0, sepConvs = 0;
  bit concPhase = 0, diffPhase = 0, outstanding = 0, expOvr = 0;
  bit lastDonePrev = 0, monOn = 0, finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  endtask

  // slot strobes and converter model, all driven just after the rising edge
  always @(posedge clk) begin
    #2;
    wrTick = (wCnt == wrPer - 1);
    wCnt   = (wCnt == wrPer - 1) ? 0 : wCnt + 1;
    rdTick = (rCnt == rdPer - 1);
    rCnt   = (rCnt == rdPer - 1) ? 0 : rCnt + 1;
    if (convDone) convDone = 1'b0;
    else if (convCnt > 0) begin
      convCnt--;
      if (convCnt == 0) convDone = 1'b1;
    end
  end

  // monitor / scoreboard at the falling edge
  always @(negedge clk) begin
    if (monOn) begin
      bit busyNow, expConv;
      busyNow = outstanding && !convDone;
      if (lastDonePrev) check(busy == 0, "R8 busy after last done", busy, 0);
      lastDonePrev = 0;
      check(overrun == expOvr, "R10 overrun", overrun, expOvr);
      if (wrStb) begin
        check(wrCell == expW[5:0], "R3 write cell", wrCell, expW);
        check(!stopReq && !busy, "R4 write during stop/busy", 1, 0);
        expW = (expW + 1) % CELLS;
      end
      if (concPhase) begin
        if (wrStb) begin
          expConv = (slotIdx >= LAT) && !(diffPhase && slotIdx == LAT) && !busyNow;
          check(convStart == expConv, "R9 conc convStart", convStart, expConv);
          if (expConv) check(rdCell == 6'(wrCell - 6'(LAT)), "R9 conc read cell",
                             rdCell, 6'(wrCell - 6'(LAT)));
          if (slotIdx >= LAT && !(diffPhase && slotIdx == LAT) && busyNow) expOvr = 1;
          slotIdx++;
        end else if (convStart) check(0, "R9 convStart outside slot", 1, 0);
      end else if (convStart) begin
        check(usePrev == diffPhase, "R6/R7 usePrev", usePrev, diffPhase);
        if (expQ.size() == 0) check(0, "R5 unexpected convStart", rdCell, -1);
        else begin
          int e;
          e = expQ.pop_front();
          check(rdCell == e[5:0], "R5 read order", rdCell, e);
        end
        sepConvs++;
      end
      if (!concPhase && convDone && outstanding && expQ.size() == 0) lastDonePrev = 1;
      if (convDone) outstanding = 0;
      if (convStart) begin
        outstanding = 1;
        convCnt = convLat;
      end
    end
  end

  task automatic tick();
    @(posedge clk); #3;
  endtask

  task automatic startRun(input bit conc, input bit diff);
    tick();
    startReq = 1; concMode = conc; diffMode = diff;
    concPhase = conc; diffPhase = diff; slotIdx = 0; sepConvs = 0;
    tick();
    startReq = 0;
    expOvr = 0;
    @(negedge clk);
    check(acquiring == 1, "R2 acquiring after start", acquiring, 1);
  endtask

  task automatic stopRun();
    tick();
    stopReq = 1;
    tick();
    stopReq = 0;
    if (!concPhase)
      for (int i = 0; i < CELLS; i++)
        if (!(diffPhase && i == 0)) expQ.push_back((expW + i) % CELLS);
    @(negedge clk);
    check(busy == 1, "R4 busy after stop", busy, 1);
    check(acquiring == 0, "R4 acquiring cleared", acquiring, 0);
  endtask

  task automatic waitWrites(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!wrStb) @(negedge clk);
    end
  endtask

  task automatic waitIdle();
    int guard = 0;
    @(negedge clk);
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check(busy == 0, "R8/R11 returns idle", busy, 0);
  endtask

  initial begin
    #(200000 * 20);
    check(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rstN = 1;
    @(negedge clk);
    check(wrCell == 0 && rdCell == 0, "R1 reset cells", wrCell, 0);
    check(!wrStb && !convStart && !acquiring && !busy && !overrun && !usePrev,
          "R1 reset flags", {wrStb, convStart, acquiring, busy, overrun, usePrev}, 0);
    monOn = 1;

    // separate, cell-only, with a write wrap
    startRun(0, 0);
    waitWrites(70);
    stopRun();
    repeat (20) tick();
    startReq = 1;                         // R2: ignored while busy
    tick();
    startReq = 0;
    @(negedge clk);
    check(acquiring == 0 && busy == 1, "R2 start ignored while busy", acquiring, 0);
    waitIdle();
    check(sepConvs == CELLS, "R6 conversion count", sepConvs, CELLS);
    check(expQ.size() == 0, "R5 all cells read", expQ.size(), 0);

    // separate, difference option
    startRun(0, 1);
    waitWrites(10);
    stopRun();
    waitIdle();
    check(sepConvs == CELLS - 1, "R7 conversion count", sepConvs, CELLS - 1);
    check(usePrev == 1, "R7 usePrev", usePrev, 1);

    // concurrent, cell-only, fast converter
    startRun(1, 0);
    waitWrites(14);
    stopRun();
    waitIdle();
    check(overrun == 0, "R10 no overrun", overrun, 0);

    // concurrent, difference, slow converter -> overrun
    convLat = 12;
    startRun(1, 1);
    waitWrites(9);
    stopRun();
    check(outstanding == 1 || busy == 0, "R11 busy while converting", busy, outstanding);
    waitIdle();
    check(overrun == 1, "R10 overrun sticky", overrun, 1);
    convLat = 3;
    startRun(1, 0);
    check(overrun == 0, "R10 cleared by start", overrun, 0);
    waitWrites(2);
    stopRun();
    waitIdle();
    finishRun();
  end
endmodule